// File: doc/BRIEF.md
# SPI Word-Register Target

This block is an SPI mode-0 target. It lets an external master read and write 32-bit words in a 16-bit register address space. Every frame opens while chip select is low with an 8-bit command and a 16-bit address. Command 0x03 then clocks a 32-bit word out on MISO. Command 0x02 clocks a 32-bit word in on MOSI. The SPI pins are brought into the system clock domain through a synchronizer. The serial clock is never used as a clock.

Two addresses are answered inside the block. The probe word at 0x0064 has a constant value. The host reads it to confirm that the byte and bit ordering agree. The configuration word at 0x0074 carries a ready flag in bit 27. This flag comes on a fixed number of clocks after reset is released. A host polls both words, and may retry up to ten times, before it uses the device. Every other address is passed to a simple register bus that has single-cycle read and write strobes. The downstream logic returns read data on the cycle after the read strobe.

The serial clock must stay high and low for at least 8 system clocks in each phase.

Top module: `spi_reg_target`

## Requirements
- R1: A frame with command 0x03 returns the 32-bit word at the frame's address in the 32 bits after the header. For an address that is not local, exactly one `bus_rd` pulse is issued with `bus_addr` equal to that address, and the word is taken from `bus_rdata` on the following cycle.
- R2: The header is shifted MSB first in this order: command byte, upper address byte, lower address byte.
- R3: In both directions the data word travels least significant byte first, and each byte is shifted MSB first.
- R4: A read of address 0x0064 returns 0x87654321.
- R5: A read of address 0x0074 returns CFG_VALUE with bit 27 replaced by the ready flag. The flag reads 0 for READY_CYCLES clocks after reset is released. After that it reads 1 and never clears.
- R6: A frame with command 0x02 that carries at least 32 data bits produces exactly one `bus_wr` pulse, carrying the frame's address and data word. Bits clocked after the 56th are ignored.
- R7: A write frame that chip select ends before all 32 data bits have arrived produces no `bus_wr` pulse, and the target word keeps its value.
- R8: A frame with any command other than 0x02 or 0x03 produces no bus strobe. MISO stays at 0 until chip select rises.
- R9: MISO is 0 during the header of every frame. MISO is also 0 from three clocks after chip select rises.
- R10: Reads of 0x0064 and 0x0074 raise no bus strobe. Writes to these two addresses are not forwarded and do not change what they read.
- R11: While reset is asserted, `bus_wr`, `bus_rd` and `spi_miso` are 0.
- R12: `bus_wr` and `bus_rd` are never high together, and each is high for exactly one cycle per access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sck | input | 1 | SPI serial clock, mode 0, asynchronous |
| spi_cs_n | input | 1 | SPI chip select, active low |
| spi_mosi | input | 1 | Serial data from the master |
| spi_miso | output | 1 | Serial data to the master, registered |
| bus_addr | output | 16 | Register bus address |
| bus_wdata | output | 32 | Register bus write data |
| bus_wr | output | 1 | Register bus write strobe, one cycle |
| bus_rd | output | 1 | Register bus read strobe, one cycle |
| bus_rdata | input | 32 | Register bus read data, valid the cycle after `bus_rd` |

## Verification
Two events can fall into the same few clocks: the commit of a write on the 56th rising serial edge, and the release of chip select that ends the frame. The bench provokes this by raising chip select just half a serial period after the last edge. It also provokes the opposite case, where a write is cut off one bit short of the commit. A behavioural model keeps a queue of the bus strobes it expects. Every clock it compares the strobes against that queue. A commit that is lost, doubled or leaked from a cut-off frame shows up as a mismatch. Reads that land on both sides of the ready-flag switch-on check the configuration word's time dependence.

// File: rtl/spi_reg_pkg.sv
package spi_reg_pkg;

  localparam logic [7:0]  CMD_READ   = 8'h03;
  localparam logic [7:0]  CMD_WRITE  = 8'h02;
  localparam int          HDR_BITS   = 24;
  localparam int          WORD_BITS  = 32;
  localparam int          FRAME_BITS = HDR_BITS + WORD_BITS;
  localparam logic [15:0] PROBE_ADDR = 16'h0064;
  localparam logic [15:0] CFG_ADDR   = 16'h0074;
  localparam logic [31:0] PROBE_WORD = 32'h8765_4321;
  localparam int          RDY_BIT    = 27;

  typedef enum logic [1:0] {SRC_PROBE, SRC_CFG, SRC_BUS} rd_src_e;

  // reverse byte order so a word can be shifted MSB first on the wire
  function automatic logic [31:0] swap_bytes(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

endpackage

// File: rtl/spi_pin_sync.sv
module spi_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic sck_i,
  input  logic cs_n_i,
  input  logic mosi_i,
  output logic sck_rise,
  output logic sck_fall,
  output logic sel_act,
  output logic mosi_s
);
  localparam int TOP = STAGES - 1;

  // each stage holds {sck, cs_n, mosi}
  logic [STAGES-1:0][2:0] pipe;
  logic                   sck_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      pipe     <= {STAGES{3'b010}};
      sck_prev <= 1'b0;
    end else begin
      pipe[0] <= {sck_i, cs_n_i, mosi_i};
      for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
      sck_prev <= pipe[TOP][2];
    end
  end

  assign sck_rise = pipe[TOP][2] & ~sck_prev;
  assign sck_fall = ~pipe[TOP][2] & sck_prev;
  assign sel_act  = ~pipe[TOP][1];
  assign mosi_s   = pipe[TOP][0];

endmodule

// File: rtl/spi_frame_engine.sv
module spi_frame_engine
  import spi_reg_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        sck_rise,
  input  logic        sck_fall,
  input  logic        sel_act,
  input  logic        mosi_s,
  input  logic        rd_valid,
  input  logic [31:0] rd_word,
  output logic        rd_req,
  output logic        wr_req,
  output logic [15:0] req_addr,
  output logic [31:0] wr_data,
  output logic        miso
);
  localparam int CW = $clog2(FRAME_BITS + 1);
  localparam logic [CW-1:0] CNT_OP   = CW'(7);
  localparam logic [CW-1:0] CNT_ADDR = CW'(HDR_BITS - 1);
  localparam logic [CW-1:0] CNT_HDR  = CW'(HDR_BITS);
  localparam logic [CW-1:0] CNT_LAST = CW'(FRAME_BITS - 1);
  localparam logic [CW-1:0] CNT_END  = CW'(FRAME_BITS);

  logic [CW-1:0] bit_cnt;
  logic [31:0]   rx_sh;
  logic [31:0]   tx_sh;
  logic [31:0]   rd_hold;
  logic [7:0]    opcode;
  logic [31:0]   rx_next;

  assign rx_next = {rx_sh[30:0], mosi_s};

  always_ff @(posedge clk) begin
    if (rst) begin
      bit_cnt  <= '0;
      rx_sh    <= '0;
      tx_sh    <= '0;
      rd_hold  <= '0;
      opcode   <= '0;
      req_addr <= '0;
      wr_data  <= '0;
      rd_req   <= 1'b0;
      wr_req   <= 1'b0;
    end else begin
      rd_req <= 1'b0;
      wr_req <= 1'b0;
      if (rd_valid) rd_hold <= rd_word;
      if (!sel_act) begin
        bit_cnt <= '0;
        tx_sh   <= '0;
        opcode  <= '0;
      end else begin
        if (sck_rise && bit_cnt != CNT_END) begin
          rx_sh   <= rx_next;
          bit_cnt <= bit_cnt + 1'b1;
          if (bit_cnt == CNT_OP) opcode <= rx_next[7:0];
          if (bit_cnt == CNT_ADDR) begin
            req_addr <= rx_next[15:0];
            rd_req   <= (opcode == CMD_READ);
          end
          if (bit_cnt == CNT_LAST && opcode == CMD_WRITE) begin
            wr_data <= swap_bytes(rx_next);
            wr_req  <= 1'b1;
          end
        end
        if (sck_fall && opcode == CMD_READ) begin
          if (bit_cnt == CNT_HDR)     tx_sh <= swap_bytes(rd_hold);
          else if (bit_cnt > CNT_HDR) tx_sh <= {tx_sh[30:0], 1'b0};
        end
      end
    end
  end

  assign miso = tx_sh[31];

endmodule

// File: rtl/spi_reg_file.sv
module spi_reg_file
  import spi_reg_pkg::*;
#(
  parameter int          READY_CYCLES = 200,
  parameter logic [31:0] CFG_VALUE    = 32'h0000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_req,
  input  logic        wr_req,
  input  logic [15:0] req_addr,
  input  logic [31:0] wr_data,
  input  logic [31:0] bus_rdata,
  output logic        rd_valid,
  output logic [31:0] rd_word,
  output logic [15:0] bus_addr,
  output logic [31:0] bus_wdata,
  output logic        bus_wr,
  output logic        bus_rd,
  output logic        cfg_ready
);
  localparam int RW = $clog2(READY_CYCLES + 1);
  localparam logic [RW-1:0] RDY_LIMIT = RW'(READY_CYCLES);

  logic [RW-1:0] rdy_cnt;
  rd_src_e       src1, src2;
  logic          v1;
  logic          hit_probe, hit_cfg, hit_local;
  logic [31:0]   cfg_word;

  always_ff @(posedge clk) begin
    if (rst) rdy_cnt <= '0;
    else if (rdy_cnt != RDY_LIMIT) rdy_cnt <= rdy_cnt + 1'b1;
  end
  assign cfg_ready = (rdy_cnt == RDY_LIMIT);

  assign hit_probe = (req_addr == PROBE_ADDR);
  assign hit_cfg   = (req_addr == CFG_ADDR);
  assign hit_local = hit_probe | hit_cfg;

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rd    <= 1'b0;
      bus_wr    <= 1'b0;
      bus_addr  <= '0;
      bus_wdata <= '0;
      src1      <= SRC_BUS;
      src2      <= SRC_BUS;
      v1        <= 1'b0;
      rd_valid  <= 1'b0;
    end else begin
      bus_rd <= rd_req & ~hit_local;
      bus_wr <= wr_req & ~hit_local;
      if ((rd_req | wr_req) && !hit_local) bus_addr <= req_addr;
      if (wr_req && !hit_local) bus_wdata <= wr_data;
      if (rd_req) src1 <= hit_probe ? SRC_PROBE : (hit_cfg ? SRC_CFG : SRC_BUS);
      v1       <= rd_req;
      src2     <= src1;
      rd_valid <= v1;
    end
  end

  always_comb begin
    cfg_word          = CFG_VALUE;
    cfg_word[RDY_BIT] = cfg_ready;
    case (src2)
      SRC_PROBE: rd_word = PROBE_WORD;
      SRC_CFG:   rd_word = cfg_word;
      default:   rd_word = bus_rdata;
    endcase
  end

endmodule

// File: rtl/spi_reg_target.sv
module spi_reg_target
  import spi_reg_pkg::*;
#(
  parameter int          SYNC_STAGES  = 2,
  parameter int          READY_CYCLES = 200,
  parameter logic [31:0] CFG_VALUE    = 32'h0140_0A5C
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        spi_sck,
  input  logic        spi_cs_n,
  input  logic        spi_mosi,
  output logic        spi_miso,
  output logic [15:0] bus_addr,
  output logic [31:0] bus_wdata,
  output logic        bus_wr,
  output logic        bus_rd,
  input  logic [31:0] bus_rdata
);
  logic        sck_rise, sck_fall, sel_act, mosi_s;
  logic        rd_req, wr_req, rd_valid, cfg_ready;
  logic [15:0] req_addr;
  logic [31:0] wr_data, rd_word;

  spi_pin_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .sck_i(spi_sck), .cs_n_i(spi_cs_n), .mosi_i(spi_mosi),
    .sck_rise(sck_rise), .sck_fall(sck_fall), .sel_act(sel_act), .mosi_s(mosi_s)
  );

  spi_frame_engine u_frame (
    .clk(clk), .rst(rst), .sck_rise(sck_rise), .sck_fall(sck_fall),
    .sel_act(sel_act), .mosi_s(mosi_s), .rd_valid(rd_valid), .rd_word(rd_word),
    .rd_req(rd_req), .wr_req(wr_req), .req_addr(req_addr), .wr_data(wr_data),
    .miso(spi_miso)
  );

  spi_reg_file #(.READY_CYCLES(READY_CYCLES), .CFG_VALUE(CFG_VALUE)) u_regs (
    .clk(clk), .rst(rst), .rd_req(rd_req), .wr_req(wr_req), .req_addr(req_addr),
    .wr_data(wr_data), .bus_rdata(bus_rdata), .rd_valid(rd_valid), .rd_word(rd_word),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .cfg_ready(cfg_ready)
  );

endmodule

// File: rtl/spi_reg_target_chk.sv
module spi_reg_target_chk #(
  parameter int READY_CYCLES = 200
) (
  input logic clk,
  input logic rst,
  input logic spi_cs_n,
  input logic spi_miso,
  input logic bus_wr,
  input logic bus_rd,
  input logic cfg_ready
);
  localparam int KW = $clog2(READY_CYCLES + 2);
  logic [KW-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != KW'(READY_CYCLES + 1)) since_rst <= since_rst + 1'b1;
  end

  assert_wr_single_R12: assert property (@(posedge clk) disable iff (rst)
    bus_wr |=> !bus_wr);
  assert_rd_single_R12: assert property (@(posedge clk) disable iff (rst)
    bus_rd |=> !bus_rd);
  assert_no_overlap_R12: assert property (@(posedge clk) disable iff (rst)
    !(bus_wr && bus_rd));
  assert_idle_miso_R9: assert property (@(posedge clk) disable iff (rst)
    ($past(spi_cs_n, 1) && $past(spi_cs_n, 2) && $past(spi_cs_n, 3)) |-> !spi_miso);
  assert_ready_early_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst < KW'(READY_CYCLES)) |-> !cfg_ready);
  assert_ready_on_R5: assert property (@(posedge clk) disable iff (rst)
    (since_rst >= KW'(READY_CYCLES)) |-> cfg_ready);
  assert_ready_sticky_R5: assert property (@(posedge clk) disable iff (rst)
    cfg_ready |=> cfg_ready);

endmodule

bind spi_reg_target spi_reg_target_chk #(.READY_CYCLES(READY_CYCLES)) u_chk (
  .clk(clk), .rst(rst), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso),
  .bus_wr(bus_wr), .bus_rd(bus_rd), .cfg_ready(cfg_ready)
);

// File: tb/spi_reg_target_test.sv
module spi_reg_target_test;
  localparam int          RDYC  = 1000;
  localparam logic [31:0] CFGV  = 32'h0140_0A5C;
  localparam int          HALF  = 8;
  localparam logic [7:0]  OP_RD = 8'h03;
  localparam logic [7:0]  OP_WR = 8'h02;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic spi_sck = 1'b0, spi_cs_n = 1'b1, spi_mosi = 1'b0;
  logic spi_miso, bus_wr, bus_rd;
  logic [15:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata = '0;

  int n_cmp = 0, n_bad = 0, cyc = 0;
  bit quiet = 1'b1;
  bit done  = 1'b0;
  logic [15:0] exp_wr_a[$];
  logic [31:0] exp_wr_d[$];
  logic [15:0] exp_rd_a[$];
  logic [31:0] mem [logic [15:0]];

  always #5 clk = ~clk;

  spi_reg_target #(.READY_CYCLES(RDYC), .CFG_VALUE(CFGV)) uut (
    .clk(clk), .rst(rst), .spi_sck(spi_sck), .spi_cs_n(spi_cs_n), .spi_mosi(spi_mosi),
    .spi_miso(spi_miso), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata)
  );

  function automatic logic [31:0] swp(input logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  function automatic bit is_local(input logic [15:0] a);
    return (a == 16'h0064) || (a == 16'h0074);
  endfunction

  // downstream register bus model: answers one cycle after the read strobe
  always @(posedge clk) begin
    if (bus_rd) bus_rdata <= mem.exists(bus_addr) ? mem[bus_addr] : {~bus_addr, bus_addr};
    if (bus_wr) mem[bus_addr] = bus_wdata;
  end

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-clock reference comparison of strobes and MISO
  always @(negedge clk) begin
    if (!rst && !done) begin
      cyc++;
      check(!(bus_wr && bus_rd), "R12 strobe overlap", {30'd0, bus_wr, bus_rd}, 32'd0);
      if (bus_wr) begin
        if (exp_wr_a.size() == 0) check(1'b0, "R7 unexpected bus_wr", {16'd0, bus_addr}, 32'd0);
        else begin
          check(bus_addr == exp_wr_a[0], "R6 write address", {16'd0, bus_addr}, {16'd0, exp_wr_a[0]});
          check(bus_wdata == exp_wr_d[0], "R3 write data", bus_wdata, exp_wr_d[0]);
          void'(exp_wr_a.pop_front());
          void'(exp_wr_d.pop_front());
        end
      end
      if (bus_rd) begin
        if (exp_rd_a.size() == 0) check(1'b0, "R10 unexpected bus_rd", {16'd0, bus_addr}, 32'd0);
        else begin
          check(bus_addr == exp_rd_a[0], "R2 read address", {16'd0, bus_addr}, {16'd0, exp_rd_a[0]});
          void'(exp_rd_a.pop_front());
        end
      end
      if (quiet) check(spi_miso === 1'b0, "R9 MISO quiet", {31'd0, spi_miso}, 32'd0);
    end
  end

  task automatic xfer(input logic [7:0] op, input logic [15:0] addr, input logic [31:0] wdata,
                      input int data_bits, output logic [31:0] rdata, output int hdr_cyc);
    logic [55:0] frame;
    logic [31:0] rx;
    frame = {op, addr, swp(wdata)};
    rx = '0;
    hdr_cyc = 0;
    @(negedge clk);
    spi_cs_n = 1'b0;
    for (int i = 0; i < 24 + data_bits; i++) begin
      spi_mosi = (i < 56) ? frame[55-i] : 1'b1;
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b1;
      if (i >= 24 && i < 56) rx = {rx[30:0], spi_miso};
      if (i == 23) begin
        hdr_cyc = cyc;
        if (op == OP_RD) quiet = 1'b0;
      end
      repeat (HALF) @(negedge clk);
      spi_sck = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    spi_cs_n = 1'b1;
    repeat (4) @(negedge clk);
    quiet = 1'b1;
    repeat (2 * HALF) @(negedge clk);
    rdata = swp(rx);
  endtask

  task automatic do_read(input logic [15:0] addr, output logic [31:0] rdata, output int hdr_cyc);
    if (!is_local(addr)) exp_rd_a.push_back(addr);
    xfer(OP_RD, addr, 32'd0, 32, rdata, hdr_cyc);
  endtask

  task automatic do_write(input logic [15:0] addr, input logic [31:0] data, input int bits);
    logic [31:0] dummy;
    int hc;
    if (!is_local(addr) && bits >= 32) begin
      exp_wr_a.push_back(addr);
      exp_wr_d.push_back(data);
    end
    xfer(OP_WR, addr, data, bits, dummy, hc);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int hc;
    repeat (3) @(negedge clk);
    check(bus_wr === 1'b0 && bus_rd === 1'b0 && spi_miso === 1'b0, "R11 reset outputs",
          {29'd0, bus_wr, bus_rd, spi_miso}, 32'd0);
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // early configuration read: ready flag still low (R5)
    do_read(16'h0074, rd, hc);
    check(rd == (CFGV | (32'(hc + 8 >= RDYC) << 27)), "R5 cfg early", rd, CFGV);
    check(rd[27] == 1'b0, "R5 ready clear before delay", {31'd0, rd[27]}, 32'd0);

    do_read(16'h0064, rd, hc);
    check(rd == 32'h8765_4321, "R4 probe word", rd, 32'h8765_4321);

    // full write then read back through the bus (R1, R3, R6)
    do_write(16'h1234, 32'hDEAD_BEEF, 32);
    do_read(16'h1234, rd, hc);
    check(rd == 32'hDEAD_BEEF, "R1 read back", rd, 32'hDEAD_BEEF);

    // address byte order: unwritten address returns model default (R2)
    do_read(16'h3412, rd, hc);
    check(rd == 32'hCBED_3412, "R2 address order", rd, 32'hCBED_3412);

    // short write is dropped (R7)
    do_write(16'h1234, 32'h1111_1111, 31);
    do_read(16'h1234, rd, hc);
    check(rd == 32'hDEAD_BEEF, "R7 short write dropped", rd, 32'hDEAD_BEEF);

    // overlong write commits once with the first 32 data bits (R6)
    do_write(16'h0456, 32'h0102_0304, 40);
    do_read(16'h0456, rd, hc);
    check(rd == 32'h0102_0304, "R6 overlong write", rd, 32'h0102_0304);

    // unknown command: no strobes, MISO held low throughout (R8)
    xfer(8'h0B, 16'h0456, 32'hFFFF_FFFF, 32, rd, hc);
    check(rd == 32'd0, "R8 unknown command MISO", rd, 32'd0);
    xfer(8'h03 ^ 8'h80, 16'h0456, 32'd0, 32, rd, hc);
    check(rd == 32'd0, "R8 near-miss command", rd, 32'd0);
    do_read(16'h0456, rd, hc);
    check(rd == 32'h0102_0304, "R8 no side effect", rd, 32'h0102_0304);

    // local words are read-only and never forwarded (R10)
    do_write(16'h0064, 32'h0000_0000, 32);
    do_write(16'h0074, 32'hFFFF_FFFF, 32);
    do_read(16'h0064, rd, hc);
    check(rd == 32'h8765_4321, "R10 probe unchanged", rd, 32'h8765_4321);

    // several distinct patterns, each byte lane different (R3)
    for (int k = 0; k < 3; k++) begin
      logic [15:0] a;
      logic [31:0] d;
      a = 16'h0800 + 16'(k * 16'h0111);
      d = 32'h00FF_A55A ^ (32'h1357_9BDF << k);
      do_write(a, d, 32);
      do_read(a, rd, hc);
      check(rd == d, "R3 pattern readback", rd, d);
    end

    // ready flag after the delay (R5)
    while (cyc < RDYC + 20) @(negedge clk);
    do_read(16'h0074, rd, hc);
    check(rd == (CFGV | 32'h0800_0000), "R5 cfg ready set", rd, CFGV | 32'h0800_0000);

    repeat (10) @(negedge clk);
    check(exp_wr_a.size() == 0, "R6 pending writes", exp_wr_a.size(), 0);
    check(exp_rd_a.size() == 0, "R1 pending reads", exp_rd_a.size(), 0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule